// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block watches the running time of a real-time clock and raises an alarm when the programmed minute, hour and day come around. Software programs an alarm minute, an alarm hour and a seven-bit day mask through a small byte-wide register port. Once per minute rollover (a one-second tick on which the seconds value is BCD 00), the block compares the current minute, hour and weekday against those settings. On a match, and only while the alarm is enabled, it latches a pending flag and pulls an active-low interrupt line.

The hour is compared in the clock's own hour encoding, so the block works unchanged whether the clock counts 24 hours or 12 hours with a PM bit. A second interrupt source, a 1 Hz level mode chosen by a three-bit select field, sets its own flag on every second tick. Both flags are cleared by software writing a zero to the flag's bit. Clearing the alarm enable also drops the alarm's pending flag.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After synchronous reset every register reads 0x00, both flags are clear and `irq_n` is high.
- R2: Writes land at address 0x8 (alarm minute, bits 6:0), 0x9 (alarm hour, bits 5:0), 0xA (day mask, bit d arms weekday d), 0xE (control A: bit 7 alarm enable, bits 2:0 periodic select) and 0xF (control B: bit 2 periodic flag, bit 1 alarm pending flag). Unused bits and all other addresses read as 0. `rd_data` is the value at `rd_addr` as it stood before the clock edge, and it appears one cycle later.
- R3: A match needs four things. `sec_tick` must be high with `cur_sec[6:0]` equal to 0. `cur_min[6:0]` must equal the alarm minute. `cur_hour[5:0]` must equal the alarm hour. The day mask bit selected by `cur_wday` must be set. A weekday code of 7 never matches.
- R4: No match occurs without a tick, with nonzero seconds, when minute or hour differ, or when the day's mask bit is clear.
- R5: A match sets the alarm pending flag only if the alarm enable was already 1 before that edge. The flag never sets without a match.
- R6: Writing control B with bit 1 = 0 clears the alarm pending flag, and bit 1 = 1 leaves it unchanged. If a qualifying match occurs in the same cycle as the clear, the flag ends up set.
- R7: Writing control A with bit 7 = 0 clears the alarm pending flag, even when a qualifying match occurs in the same cycle.
- R8: `irq_n` is low in the cycle after either of two conditions holds: the enable and the alarm pending flag are both set, or the periodic select is 4 and the periodic flag is set. In every other case it is high.
- R9: With periodic select 4, every `sec_tick` sets the periodic flag, and writing control B with bit 2 = 0 clears it unless a tick arrives in the same cycle. Any other select value never sets the flag.
- R10: In 12-hour encoding, bit 5 of the hour (PM) takes part in the comparison. An alarm hour of 0x32 matches 0x32 but not 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Registered read data |
| sec_tick | input | 1 | One-cycle pulse when a new second value is presented |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hour, clock encoding |
| cur_wday | input | WDAY_W | Current weekday code, 0 to DAYS-1 |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The bench uses the default parameters: DAYS = 7 and ADDR_W = 4. With these values the three-bit weekday input has one spare code, 7, so the bench can drive a weekday that selects no mask bit against a fully armed mask. The four-bit address space leaves unmapped addresses for the read-as-zero check. Random traffic pulls the current minute and hour toward the programmed alarm, so matches, same-cycle clear and set collisions and enable drops all happen often.

// File: rtl/rtca_pkg.sv
package rtca_pkg;
  localparam int BYTE_W    = 8;
  localparam int MIN_W     = 7;
  localparam int HOUR_W    = 6;
  localparam int SEL_W     = 3;

  localparam int REG_AMIN  = 8;
  localparam int REG_AHOUR = 9;
  localparam int REG_AMASK = 10;
  localparam int REG_CTLA  = 14;
  localparam int REG_CTLB  = 15;

  localparam int EN_BIT    = 7;
  localparam int PF_BIT    = 2;
  localparam int AF_BIT    = 1;

  localparam logic [SEL_W-1:0] SEL_1HZ = 3'd4;
endpackage

// File: rtl/rtca_regfile.sv
module rtca_regfile
  import rtca_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DAYS   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [MIN_W-1:0]  amin,
  output logic [HOUR_W-1:0] ahour,
  output logic [DAYS-1:0]   dmask,
  output logic              alarm_en,
  output logic [SEL_W-1:0]  per_sel,
  output logic              en_clear,
  output logic              clr_alarm,
  output logic              clr_period
);
  logic hit_ctla, hit_ctlb;

  assign hit_ctla   = wr_en && (wr_addr == ADDR_W'(REG_CTLA));
  assign hit_ctlb   = wr_en && (wr_addr == ADDR_W'(REG_CTLB));
  assign en_clear   = hit_ctla && !wr_data[EN_BIT];
  assign clr_alarm  = hit_ctlb && !wr_data[AF_BIT];
  assign clr_period = hit_ctlb && !wr_data[PF_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      amin     <= '0;
      ahour    <= '0;
      dmask    <= '0;
      alarm_en <= 1'b0;
      per_sel  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(REG_AMIN):  amin  <= wr_data[MIN_W-1:0];
        ADDR_W'(REG_AHOUR): ahour <= wr_data[HOUR_W-1:0];
        ADDR_W'(REG_AMASK): dmask <= wr_data[DAYS-1:0];
        ADDR_W'(REG_CTLA): begin
          alarm_en <= wr_data[EN_BIT];
          per_sel  <= wr_data[SEL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // R7: an enable-drop write leaves the enable at 0
  a_r7_en_drop: assert property (@(posedge clk) disable iff (rst)
    en_clear |=> !alarm_en);
endmodule

// File: rtl/rtca_match.sv
module rtca_match
  import rtca_pkg::*;
#(
  parameter int DAYS   = 7,
  parameter int WDAY_W = $clog2(DAYS)
) (
  input  logic              sec_tick,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic [MIN_W-1:0]  amin,
  input  logic [HOUR_W-1:0] ahour,
  input  logic [DAYS-1:0]   dmask,
  output logic              hit
);
  logic [DAYS-1:0] day_sel;
  logic            day_ok, rollover, time_eq;

  for (genvar d = 0; d < DAYS; d++) begin : g_day
    assign day_sel[d] = dmask[d] && (cur_wday == WDAY_W'(d));
  end

  assign day_ok   = |day_sel;
  assign rollover = sec_tick && (cur_sec[MIN_W-1:0] == '0);
  // hour compared raw: covers 24h values and the 12h PM bit alike
  assign time_eq  = (cur_min[MIN_W-1:0] == amin) && (cur_hour[HOUR_W-1:0] == ahour);
  assign hit      = rollover && time_eq && day_ok;
endmodule

// File: rtl/rtca_flags.sv
module rtca_flags
  import rtca_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_tick,
  input  logic             hit,
  input  logic             alarm_en,
  input  logic [SEL_W-1:0] per_sel,
  input  logic             en_clear,
  input  logic             clr_alarm,
  input  logic             clr_period,
  output logic             alarm_flag,
  output logic             period_flag,
  output logic             irq_n
);
  logic set_alarm, set_period, per_on;

  assign set_alarm  = hit && alarm_en;
  assign per_on     = (per_sel == SEL_1HZ);
  assign set_period = sec_tick && per_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_flag  <= 1'b0;
      period_flag <= 1'b0;
      irq_n       <= 1'b1;
    end else begin
      if (en_clear)       alarm_flag <= 1'b0;
      else if (set_alarm) alarm_flag <= 1'b1;
      else if (clr_alarm) alarm_flag <= 1'b0;

      if (set_period)      period_flag <= 1'b1;
      else if (clr_period) period_flag <= 1'b0;

      irq_n <= !((alarm_en && alarm_flag) || (per_on && period_flag));
    end
  end

  // R5: an enabled match latches the pending flag
  a_r5_set: assert property (@(posedge clk) disable iff (rst)
    (hit && alarm_en && !en_clear) |=> alarm_flag);
  // R5: the flag never rises without an enabled match
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && !(hit && alarm_en)) |=> !alarm_flag);
  // R6: a zero written to the flag bit clears it when no match competes
  a_r6_sw_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_alarm && !(hit && alarm_en)) |=> !alarm_flag);
  // R7: dropping the enable removes any pending alarm
  a_r7_en_clear: assert property (@(posedge clk) disable iff (rst)
    en_clear |=> !alarm_flag);
  // R8: enabled pending alarm pulls the line low next cycle
  a_r8_irq_low: assert property (@(posedge clk) disable iff (rst)
    (alarm_en && alarm_flag) |=> !irq_n);
  // R8: no active source leaves the line high
  a_r8_irq_high: assert property (@(posedge clk) disable iff (rst)
    (!(alarm_en && alarm_flag) && !(per_on && period_flag)) |=> irq_n);
  // R9: a tick in 1 Hz mode sets the periodic flag
  a_r9_period_set: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && per_on) |=> period_flag);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtca_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DAYS   = 7,
  parameter int WDAY_W = $clog2(DAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              sec_tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [WDAY_W-1:0] cur_wday,
  output logic              irq_n
);
  logic [MIN_W-1:0]  amin;
  logic [HOUR_W-1:0] ahour;
  logic [DAYS-1:0]   dmask;
  logic              alarm_en, en_clear, clr_alarm, clr_period, hit;
  logic              alarm_flag, period_flag;
  logic [SEL_W-1:0]  per_sel;
  logic [7:0]        rd_next;

  rtca_regfile #(.ADDR_W(ADDR_W), .DAYS(DAYS)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .amin(amin), .ahour(ahour), .dmask(dmask), .alarm_en(alarm_en),
    .per_sel(per_sel), .en_clear(en_clear), .clr_alarm(clr_alarm),
    .clr_period(clr_period)
  );

  rtca_match #(.DAYS(DAYS), .WDAY_W(WDAY_W)) match_i (
    .sec_tick(sec_tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_wday(cur_wday), .amin(amin), .ahour(ahour),
    .dmask(dmask), .hit(hit)
  );

  rtca_flags flags_i (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .hit(hit), .alarm_en(alarm_en),
    .per_sel(per_sel), .en_clear(en_clear), .clr_alarm(clr_alarm),
    .clr_period(clr_period), .alarm_flag(alarm_flag),
    .period_flag(period_flag), .irq_n(irq_n)
  );

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      ADDR_W'(REG_AMIN):  rd_next[MIN_W-1:0]  = amin;
      ADDR_W'(REG_AHOUR): rd_next[HOUR_W-1:0] = ahour;
      ADDR_W'(REG_AMASK): rd_next[DAYS-1:0]   = dmask;
      ADDR_W'(REG_CTLA): begin
        rd_next[EN_BIT]    = alarm_en;
        rd_next[SEL_W-1:0] = per_sel;
      end
      ADDR_W'(REG_CTLB): begin
        rd_next[PF_BIT] = period_flag;
        rd_next[AF_BIT] = alarm_flag;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R2: an unmapped address always reads back zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(0)) |=> (rd_data == 8'h00));
endmodule

// File: tb/rtc_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_unit_tb_top;
  localparam int ADDR_W = 4;
  localparam int DAYS   = 7;
  localparam int WDAY_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, wr_en, sec_tick, irq_n;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data, cur_sec, cur_min, cur_hour;
  logic [WDAY_W-1:0] cur_wday;

  rtc_alarm_unit #(.ADDR_W(ADDR_W), .DAYS(DAYS)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_wday(cur_wday), .irq_n(irq_n)
  );

  int checks = 0, errors = 0, rot = 0, rd_fix = -1;
  bit done = 0;
  string tag = "R1";

  // bench model state
  logic [6:0] m_amin, m_mask;
  logic [5:0] m_ahour;
  logic [2:0] m_sel;
  logic m_en, m_af, m_pf, m_nirq;
  logic [7:0] m_rd;

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h8: return {1'b0, m_amin};
      4'h9: return {2'b00, m_ahour};
      4'hA: return {1'b0, m_mask};
      4'hE: return {m_en, 4'b0000, m_sel};
      4'hF: return {5'b00000, m_pf, m_af, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_hit(input logic t, input logic [7:0] s, m, h,
                                   input logic [2:0] wd);
    return t && (s[6:0] == 7'd0) && (m[6:0] == m_amin) && (h[5:0] == m_ahour)
           && (wd < 3'd7) && m_mask[wd];
  endfunction

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [3:0] a, input logic [7:0] d,
                      input logic t, input logic [7:0] s, m, h, input logic [2:0] wd);
    logic hit, en_clr, n_af, n_pf, n_nirq;
    logic [7:0] n_rd;
    logic [3:0] rl [6] = '{4'h8, 4'h9, 4'hA, 4'hE, 4'hF, 4'h3};
    wr_en = w; wr_addr = a; wr_data = d; sec_tick = t;
    cur_sec = s; cur_min = m; cur_hour = h; cur_wday = wd;
    rd_addr = (rd_fix >= 0) ? 4'(rd_fix) : rl[rot % 6];
    rot++;
    hit    = exp_hit(t, s, m, h, wd);
    en_clr = w && (a == 4'hE) && !d[7];
    if (en_clr)                          n_af = 1'b0;
    else if (hit && m_en)                n_af = 1'b1;
    else if (w && a == 4'hF && !d[1])    n_af = 1'b0;
    else                                 n_af = m_af;
    if (t && m_sel == 3'd4)              n_pf = 1'b1;
    else if (w && a == 4'hF && !d[2])    n_pf = 1'b0;
    else                                 n_pf = m_pf;
    n_nirq = !((m_en && m_af) || (m_sel == 3'd4 && m_pf));
    n_rd   = exp_read(rd_addr);
    @(posedge clk); #1;
    if (w) begin
      case (a)
        4'h8: m_amin  = d[6:0];
        4'h9: m_ahour = d[5:0];
        4'hA: m_mask  = d[6:0];
        4'hE: begin m_en = d[7]; m_sel = d[2:0]; end
        default: ;
      endcase
    end
    m_af = n_af; m_pf = n_pf; m_nirq = n_nirq; m_rd = n_rd;
    check("irq_n", {7'b0, irq_n}, {7'b0, m_nirq});
    check("rd_data", rd_data, m_rd);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 8'h05, 8'h00, 8'h00, 3'd0);
  endtask
  task automatic tk(input logic [7:0] s, m, h, input logic [2:0] wd);
    step(1'b0, 4'h0, 8'h00, 1'b1, s, m, h, wd);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 8'h00, 1'b0, 8'h05, 8'h00, 8'h00, 3'd0);
  endtask
  task automatic peek(input logic [3:0] a, input logic [7:0] exp);
    rd_fix = int'(a);
    idle(2);
    check("readback", rd_data, exp);
    rd_fix = -1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; sec_tick = 0;
    cur_sec = 0; cur_min = 0; cur_hour = 0; cur_wday = 0;
    m_amin = 0; m_mask = 0; m_ahour = 0; m_sel = 0; m_en = 0; m_af = 0; m_pf = 0;
    m_nirq = 1; m_rd = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    check("irq_n reset", {7'b0, irq_n}, 8'h01);
    check("rd_data reset", rd_data, 8'h00);
    idle(6);

    tag = "R2";
    wr(4'h8, 8'hC5); peek(4'h8, 8'h45);
    wr(4'h9, 8'hE3); peek(4'h9, 8'h23);
    wr(4'hA, 8'h84); peek(4'hA, 8'h04);
    wr(4'hE, 8'hFA); peek(4'hE, 8'h82);
    wr(4'h3, 8'hFF); peek(4'h3, 8'h00);

    tag = "R3";  // alarm 45 min, hour 23, Tuesday (bit 2), enabled
    tk(8'h00, 8'h45, 8'h23, 3'd2); peek(4'hF, 8'h02);
    check("R8 irq low", {7'b0, irq_n}, 8'h00);
    tag = "R6";
    wr(4'hF, 8'h02); peek(4'hF, 8'h02);
    wr(4'hF, 8'h00); peek(4'hF, 8'h00);
    tag = "R4";
    tk(8'h01, 8'h45, 8'h23, 3'd2); tk(8'h00, 8'h45, 8'h23, 3'd3);
    tk(8'h00, 8'h44, 8'h23, 3'd2); tk(8'h00, 8'h45, 8'h22, 3'd2);
    step(1'b0, 4'h0, 8'h00, 1'b0, 8'h00, 8'h45, 8'h23, 3'd2);
    peek(4'hF, 8'h00);
    tag = "R3";
    wr(4'hA, 8'h7F); tk(8'h00, 8'h45, 8'h23, 3'd7); peek(4'hF, 8'h00);
    tk(8'h00, 8'h45, 8'h23, 3'd6); peek(4'hF, 8'h02);
    tag = "R7";
    wr(4'hE, 8'h00); peek(4'hF, 8'h00);
    check("R8 irq high", {7'b0, irq_n}, 8'h01);
    tag = "R5";
    tk(8'h00, 8'h45, 8'h23, 3'd1); peek(4'hF, 8'h00);
    tag = "R7";
    wr(4'hE, 8'h80);
    step(1'b1, 4'hE, 8'h00, 1'b1, 8'h00, 8'h45, 8'h23, 3'd1); peek(4'hF, 8'h00);
    tag = "R6";
    wr(4'hE, 8'h80);
    step(1'b1, 4'hF, 8'h00, 1'b1, 8'h00, 8'h45, 8'h23, 3'd1); peek(4'hF, 8'h02);
    wr(4'hF, 8'h00);
    tag = "R10";
    wr(4'h9, 8'h32);
    tk(8'h00, 8'h45, 8'h12, 3'd0); peek(4'hF, 8'h00);
    tk(8'h00, 8'h45, 8'h32, 3'd0); peek(4'hF, 8'h02);
    wr(4'hE, 8'h00);
    tag = "R9";
    wr(4'hE, 8'h03); tk(8'h07, 8'h00, 8'h00, 3'd0); peek(4'hF, 8'h00);
    wr(4'hE, 8'h04); tk(8'h08, 8'h00, 8'h00, 3'd0); peek(4'hF, 8'h04);
    check("irq low periodic", {7'b0, irq_n}, 8'h00);
    wr(4'hF, 8'h02); peek(4'hF, 8'h00);
    check("irq high periodic", {7'b0, irq_n}, 8'h01);

    tag = "R3-R9 random";
    for (int i = 0; i < 4000; i++) begin
      logic w, t;
      logic [3:0] a;
      logic [7:0] d, s, m, h;
      logic [2:0] wd;
      int pick;
      w = ($urandom % 10) < 3;
      pick = $urandom % 6;
      a = (pick == 0) ? 4'h8 : (pick == 1) ? 4'h9 : (pick == 2) ? 4'hA :
          (pick == 3) ? 4'hE : (pick == 4) ? 4'hF : 4'($urandom);
      d = 8'($urandom);
      if (a == 4'hA && ($urandom % 2)) d = 8'h7F;
      if (a == 4'hE) d = {d[7], 4'b0, (($urandom % 2) ? 3'd4 : 3'(d[2:0]))};
      t  = ($urandom % 2) == 0;
      s  = (($urandom % 3) != 0) ? 8'h00 : 8'($urandom % 60);
      m  = (($urandom % 4) != 0) ? {1'b0, m_amin} : 8'($urandom % 60);
      h  = (($urandom % 4) != 0) ? {2'b0, m_ahour} : 8'($urandom % 36);
      wd = 3'($urandom);
      step(w, a, d, t, s, m, h, wd);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule